// File: doc/BRIEF.md
# Serial Augmented CRC-4 Remainder Engine

This block divides a serial message by the generator x^4 + x^3 + 1 and leaves the 4-bit remainder on its output. Message bits arrive one per accepted clock, most significant bit first. Each accepted bit enters the bottom of a 4-bit remainder register. The register shifts toward the top, and the bit that falls out of the top decides whether the mask 1001 is folded back in. This is the augmented-message method: the remainder is only correct once four zero bits have followed the message through the register.

The caller starts a message with a synchronous clear. It then presents bits with a valid strobe and marks the final message bit with a last flag. The block then runs the four zero flush steps by itself on the next four clocks. A one-cycle done pulse announces that the remainder is final. The remainder then holds until the next clear. The reset is active-low and asynchronous; its release is synchronised inside the block.

Top module: `crc4_augmented`

## Requirements
- R1: While reset is asserted, and after it is released, `crc_o` reads 0000, `done_o` is low, and the block accepts message bits.
- R2: On a clock where a message bit is accepted, the register shifts one place toward bit 3 and the message bit enters bit 0. If the old bit 3 was 1, the shifted value is then XORed with 1001 (the generator 11001 without its leading 1). Starting from 0000, the bits 1,0,0,0 give 1000, and a further 1 gives 1000.
- R3: While accepting bits, a clock with `valid_i` low leaves `crc_o` unchanged.
- R4: A bit accepted with `last_i` high ends the message. The next four clocks each shift a zero into the register, whatever `valid_i`, `bit_i` and `last_i` carry.
- R5: `done_o` is high for exactly the one cycle that follows the fourth flush step. In that cycle, `crc_o` equals the remainder of (message × x^4) divided by 11001.
- R6: After the done pulse, `crc_o` keeps the remainder and ignores every valid bit until `clear_i` is asserted.
- R7: `clear_i` is synchronous. It sets `crc_o` to 0000, holds `done_o` low, and returns the block to accepting bits. It takes priority over an accepted bit and over a flush step in the same cycle.
- R8: `last_i` has no effect on a clock where `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear; starts a new message |
| valid_i | input | 1 | Qualifies `bit_i` and `last_i` |
| bit_i | input | 1 | Serial message bit, most significant first |
| last_i | input | 1 | Marks the accepted bit as the final message bit |
| crc_o | output | 4 | Remainder register |
| done_o | output | 1 | One-cycle pulse when the remainder is final |

## Verification
Two functions can fall in the same cycle: a clear and the acceptance of a message bit, and a clear and the fourth flush step that would raise the done pulse. The bench provokes the first by raising `clear_i` together with a valid 1 bit in the middle of a message. It provokes the second by raising `clear_i` exactly three clocks after the last bit. In both cases the clear must win. The bench judges this by reading 0000 and a low `done_o` on the following cycle, and by then running a fresh message to a correct remainder.

// File: rtl/crc4_aug_pkg.sv
package crc4_aug_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_HOLD  = 2'd2
  } crc_phase_e;

  localparam int unsigned CRC_WIDTH_DEF = 4;
  localparam logic [3:0]  CRC_MASK_DEF  = 4'b1001;

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/crc_step_lfsr.sv
module crc_step_lfsr #(
  parameter int unsigned          WIDTH = 4,
  parameter logic [WIDTH-1:0]     MASK  = WIDTH'(9)
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             in_bit_i,
  output logic [WIDTH-1:0] nxt_o
);

  logic feedback;
  assign feedback = cur_i[WIDTH-1];

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    if (g == 0) begin : g_low
      assign nxt_o[g] = in_bit_i ^ (feedback & MASK[g]);
    end else begin : g_up
      assign nxt_o[g] = cur_i[g-1] ^ (feedback & MASK[g]);
    end
  end

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import crc4_aug_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       shift_en_o,
  output logic       msg_sel_o,
  output crc_phase_e phase_o,
  output logic       done_o
);

  localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  crc_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             take_bit, flush_step, flush_end;

  assign take_bit   = (phase_q == ST_RUN) && valid_i;
  assign flush_step = (phase_q == ST_FLUSH);
  assign flush_end  = flush_step && (cnt_q == CNT_LAST);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (clear_i) begin
      phase_d = ST_RUN;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        ST_RUN: begin
          if (valid_i && last_i) begin
            phase_d = ST_FLUSH;
            cnt_d   = '0;
          end
        end
        ST_FLUSH: begin
          if (flush_end) begin
            phase_d = ST_HOLD;
            done_d  = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HOLD: phase_d = ST_HOLD;
        default: phase_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_RUN;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign shift_en_o = !clear_i && (take_bit || flush_step);
  assign msg_sel_o  = (phase_q == ST_RUN);
  assign phase_o    = phase_q;
  assign done_o     = done_q;

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_after_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(phase_q) == ST_FLUSH));

  assert_done_enters_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == ST_HOLD));

  assert_flush_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && phase_q == ST_RUN && valid_i && last_i) |=> (phase_q == ST_FLUSH));

endmodule

// File: rtl/crc4_augmented.sv
module crc4_augmented
  import crc4_aug_pkg::*;
#(
  parameter int unsigned      WIDTH = CRC_WIDTH_DEF,
  parameter logic [WIDTH-1:0] MASK  = WIDTH'(CRC_MASK_DEF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic [WIDTH-1:0] crc_o,
  output logic             done_o
);

  logic             rst_n;
  logic             shift_en, msg_sel, done;
  crc_phase_e       phase;
  logic [WIDTH-1:0] crc_q, crc_d, step_val;
  logic             in_bit;

  crc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  crc_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clear_i    (clear_i),
    .valid_i    (valid_i),
    .last_i     (last_i),
    .shift_en_o (shift_en),
    .msg_sel_o  (msg_sel),
    .phase_o    (phase),
    .done_o     (done)
  );

  assign in_bit = msg_sel ? bit_i : 1'b0;

  crc_step_lfsr #(.WIDTH(WIDTH), .MASK(MASK)) u_step (
    .cur_i    (crc_q),
    .in_bit_i (in_bit),
    .nxt_o    (step_val)
  );

  always_comb begin
    crc_d = crc_q;
    if (clear_i) begin
      crc_d = '0;
    end else if (shift_en) begin
      crc_d = step_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign crc_o  = crc_q;
  assign done_o = done;

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!clear_i && !valid_i && phase == ST_RUN) |=> $stable(crc_q));

  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!clear_i && phase == ST_HOLD) |=> $stable(crc_q));

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    clear_i |=> (crc_q == '0 && !done_o));

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_n |-> (crc_q == '0 && !done_o));

endmodule

// File: tb/crc4_augmented_bench.sv
`timescale 1ns/1ps
module crc4_augmented_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       last_i = 1'b0;
  logic [3:0] crc_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  crc4_augmented u_crc4_augmented (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (valid_i),
    .bit_i   (bit_i),
    .last_i  (last_i),
    .crc_o   (crc_o),
    .done_o  (done_o)
  );

  function automatic logic [3:0] ref_rem(input logic [63:0] msg, input int n);
    logic [4:0] r = 5'd0;
    for (int i = n - 1; i >= -4; i--) begin
      r = {r[3:0], (i >= 0) ? msg[i] : 1'b0};
      if (r[4]) r = r ^ 5'b11001;
    end
    return r[3:0];
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic send_bit(input logic b, input logic lst, input int gap);
    valid_i = 1'b1; bit_i = b; last_i = lst;
    @(negedge clk_i);
    valid_i = 1'b0; bit_i = 1'b0; last_i = 1'b0;
    for (int k = 0; k < gap; k++) @(negedge clk_i);
  endtask

  task automatic send_msg(input logic [63:0] msg, input int n, input int gap);
    for (int i = n - 1; i >= 0; i--) send_bit(msg[i], (i == 0), (i == 0) ? 0 : gap);
  endtask

  // after the last bit: three flush steps without done, fourth raises done (R4, R5)
  task automatic finish_and_check(input logic [63:0] msg, input int n, input bit noisy, input string tag);
    if (noisy) begin valid_i = 1'b1; bit_i = 1'b1; last_i = 1'b1; end
    repeat (3) @(negedge clk_i);
    check({3'b0, done_o}, 4'd0, {tag, " R5 done early"});
    @(negedge clk_i);
    valid_i = 1'b0; bit_i = 1'b0; last_i = 1'b0;
    check({3'b0, done_o}, 4'd1, {tag, " R5 done"});
    check(crc_o, ref_rem(msg, n), {tag, " R5 remainder"});
  endtask

  task automatic test_reset();
    check(crc_o, 4'd0, "R1 crc in reset");
    check({3'b0, done_o}, 4'd0, "R1 done in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(crc_o, 4'd0, "R1 crc after release");
    send_bit(1'b1, 1'b0, 0);
    check(crc_o, 4'b0001, "R1 accepts after release");
  endtask

  task automatic test_steps();
    do_clear();
    send_bit(1'b1, 1'b0, 0);
    check(crc_o, 4'b0001, "R2 first bit");
    send_bit(1'b0, 1'b0, 0);
    send_bit(1'b0, 1'b0, 0);
    send_bit(1'b0, 1'b0, 0);
    check(crc_o, 4'b1000, "R2 shift to top");
    send_bit(1'b1, 1'b0, 0);
    check(crc_o, 4'b1000, "R2 feedback xor");
    bit_i = 1'b1; last_i = 1'b1;
    repeat (3) @(negedge clk_i);
    bit_i = 1'b0; last_i = 1'b0;
    check(crc_o, 4'b1000, "R3 idle hold");
    check({3'b0, done_o}, 4'd0, "R8 last without valid");
  endtask

  task automatic test_message(input logic [63:0] msg, input int n, input int gap, input string tag);
    do_clear();
    send_msg(msg, n, gap);
    finish_and_check(msg, n, 1'b0, tag);
    valid_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i);
    check({3'b0, done_o}, 4'd0, {tag, " R5 single pulse"});
    repeat (2) @(negedge clk_i);
    valid_i = 1'b0; bit_i = 1'b0;
    check(crc_o, ref_rem(msg, n), {tag, " R6 result held"});
  endtask

  task automatic test_flush_noise();
    do_clear();
    send_msg(64'h5B, 7, 0);
    finish_and_check(64'h5B, 7, 1'b1, "R4 inputs ignored in flush");
  endtask

  task automatic test_last_gated();
    do_clear();
    send_bit(1'b1, 1'b0, 0);
    send_bit(1'b0, 1'b0, 0);
    last_i = 1'b1;
    @(negedge clk_i);
    last_i = 1'b0;
    send_bit(1'b1, 1'b0, 0);
    send_bit(1'b1, 1'b1, 0);
    finish_and_check(64'hB, 4, 1'b0, "R8 gated last");
  endtask

  task automatic test_clear_collisions();
    do_clear();
    send_bit(1'b1, 1'b0, 0);
    send_bit(1'b1, 1'b0, 0);
    clear_i = 1'b1; valid_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0; valid_i = 1'b0; bit_i = 1'b0;
    check(crc_o, 4'd0, "R7 clear beats bit");
    send_msg(64'h3, 2, 0);
    finish_and_check(64'h3, 2, 1'b0, "R7 after clear");
    do_clear();
    send_msg(64'hD, 4, 0);
    repeat (3) @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    check({3'b0, done_o}, 4'd0, "R7 clear beats done");
    check(crc_o, 4'd0, "R7 clear beats flush");
    send_bit(1'b1, 1'b0, 0);
    check(crc_o, 4'b0001, "R7 accepting again");
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    test_reset();
    test_steps();
    test_message(64'h1, 1, 0, "msg1");
    test_message(64'h6B, 7, 0, "msg7");
    test_message(64'hA5, 8, 2, "msg8 gaps");
    test_message(64'hBEEF, 16, 1, "msg16");
    test_message(64'h0, 5, 0, "zeros");
    test_message(64'hFFFF_FFFF, 32, 0, "ones");
    test_flush_noise();
    test_last_gated();
    test_clear_collisions();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule